// File: doc/BRIEF.md
# Three-Target Configuration SPI Master

This block programs the configuration slaves on a data-converter board. There are three of them: one converter and two clock chips, a fan-out buffer and a synthesizer. A requester presents a slave index, a read flag and a payload of up to 32 bits. The master selects that slave's chip select and clocks out a word whose length and wire mode belong to that slave. When the word is finished it raises a one-cycle done pulse, together with any read byte.

The converter uses separate out and in data lines. Both clock chips share a single bidirectional data line, which appears here as an output, an output enable and an input. During a read on the shared line, the master turns the line around partway through the word. The serial clock comes from a divider of the system clock that is set at run time. Chip select stays asserted for one half-period before the first clock edge of the word and for one half-period after the last.

Top module: `cfg_spi_master`

## Requirements
- R1: Target index 0 is the converter (4-wire, 24-bit), index 1 is the fan-out buffer (3-wire, 24-bit) and index 2 is the synthesizer (3-wire, 32-bit). Target i is selected by driving `cs_n[i]` low.
- R2: At most one chip-select bit is low at any time. It stays low without change from the accepting cycle until the transfer ends.
- R3: Data goes out MSB first. A 24-bit word is {req_read, req_word[22:0]}, so bit 23 always carries the read flag (1 = read). A 32-bit word is req_word[31:0]. Exactly 24 or 32 rising SCLK edges occur.
- R4: SCLK idles low. Output data changes only when SCLK falls and stays stable while SCLK is high. Input data is sampled when SCLK rises.
- R5: In a converter read, the bits sampled from `miso` on rising edges 16 to 23 form `rd_data[7:0]`, MSB first.
- R6: `sdio_oe` is high for every bit of a 3-wire write. In a 3-wire read it is high for bits 0 to 15 and low for bits 16 to 23, and those last 8 bits are sampled from `sdio_in` into `rd_data`. `sdio_oe` is never high while the converter is selected.
- R7: A read request to target 2 asserts no chip select and produces no SCLK edges. It gives `done` in the next cycle with `rd_data` = 0.
- R8: A request to target index 3 asserts no chip select and produces no SCLK edges. It gives `done` in the next cycle with `rd_data` = 0.
- R9: Each SCLK half-period lasts H = max(clk_div, 1) system clocks. Chip select falls H cycles before the first rising edge and rises H cycles after the last falling edge.
- R10: `busy` is high from the cycle after acceptance until the transfer ends. `done` is high for exactly one cycle, on the same edge where chip select rises.
- R11: A request presented while `busy` is high is ignored. No other chip select goes low and no extra `done` appears.
- R12: A completed write reports `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 8 | SCLK half-period in system clocks (0 treated as 1) |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_target | input | 2 | Slave index |
| req_read | input | 1 | 1 = read, 0 = write |
| req_word | input | 32 | Payload, MSB first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read byte, valid with done |
| sclk | output | 1 | Serial clock |
| cs_n | output | 3 | Active-low chip selects, one per slave |
| mosi | output | 1 | Converter data out |
| miso | input | 1 | Converter data in |
| sdio_out | output | 1 | Shared-line data driven by the master |
| sdio_oe | output | 1 | Shared-line output enable |
| sdio_in | input | 1 | Shared-line data seen by the master |

## Verification
The bench watches the turnaround of the shared line. It models the line as a loopback whenever `sdio_oe` stays high, so a master that releases late or never reads back its own bits instead of the slave byte. It forces the read flag into bit 23 against a payload bit of the opposite value, which catches a design that shifts the raw word. Edge-to-edge timing is measured for several divider values, including 0, so a wrong setup, hold or half-period count shows up as a cycle mismatch. Two kinds of request should not start a transfer: a read to the write-only target and a request to the unused index. Each must complete with no chip select and zero data. A request injected while busy must leave the running transfer unchanged.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int NUM_TGT  = 3;
    localparam int TGT_W    = 2;
    localparam int WORD_MAX = 32;
    localparam int IDX_W    = $clog2(WORD_MAX);
    localparam int RD_BITS  = 8;
    localparam int TURN_BIT = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD
    } xfer_state_e;

    typedef struct packed {
        logic three_wire;
        logic long_word;
        logic readable;
    } tgt_prof_t;
endpackage

// File: rtl/spi_target_map.sv
module spi_target_map
    import spi_cfg_pkg::*;
(
    input  logic [TGT_W-1:0] idx,
    output logic             present,
    output tgt_prof_t        prof
);
    localparam tgt_prof_t PROF_TAB [NUM_TGT] = '{
        '{three_wire: 1'b0, long_word: 1'b0, readable: 1'b1},
        '{three_wire: 1'b1, long_word: 1'b0, readable: 1'b1},
        '{three_wire: 1'b1, long_word: 1'b1, readable: 1'b0}
    };

    logic      [NUM_TGT-1:0] hit;
    tgt_prof_t               masked [NUM_TGT];

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
        assign hit[g]    = (int'(idx) == g);
        assign masked[g] = hit[g] ? PROF_TAB[g] : '0;
    end

    always_comb begin
        prof = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            prof = prof | masked[i];
        end
    end

    assign present = |hit;
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase_end
);
    logic [DIV_W-1:0] hp;
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign hp        = (div == '0) ? DIV_W'(1) : div;
    assign phase_end = run && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = hp - DIV_W'(1);
        end else if (run) begin
            cnt_d = (cnt_q == '0) ? hp - DIV_W'(1) : cnt_q - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !run);
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg
    import spi_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WORD_MAX-1:0] load_word,
    input  logic                shift,
    input  logic                sample,
    input  logic                sample_bit,
    output logic                tx_next,
    output logic [RD_BITS-1:0]  rx_byte
);
    typedef struct packed {
        logic [WORD_MAX-1:0] tx;
        logic [RD_BITS-1:0]  rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx = load_word;
            sh_d.rx = '0;
        end else begin
            if (shift)  sh_d.tx = {sh_q.tx[WORD_MAX-2:0], 1'b0};
            if (sample) sh_d.rx = {sh_q.rx[RD_BITS-2:0], sample_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign tx_next = sh_q.tx[WORD_MAX-2];
    assign rx_byte = sh_q.rx;

    // R3
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && (shift || sample)));
endmodule

// File: rtl/cfg_spi_master.sv
module cfg_spi_master
    import spi_cfg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    clk_div,
    input  logic                req_valid,
    input  logic [TGT_W-1:0]    req_target,
    input  logic                req_read,
    input  logic [WORD_MAX-1:0] req_word,
    output logic                busy,
    output logic                done,
    output logic [RD_BITS-1:0]  rd_data,
    output logic                sclk,
    output logic [NUM_TGT-1:0]  cs_n,
    output logic                mosi,
    input  logic                miso,
    output logic                sdio_out,
    output logic                sdio_oe,
    input  logic                sdio_in
);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(23);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(WORD_MAX - 1);
    localparam logic [IDX_W-1:0] TURN_IDX   = IDX_W'(TURN_BIT);

    typedef struct packed {
        xfer_state_e        st;
        logic [NUM_TGT-1:0] cs_n;
        logic               sclk;
        logic               dout;
        logic               oe;
        logic               three_wire;
        logic               is_read;
        logic               long_word;
        logic [IDX_W-1:0]   bit_idx;
        logic               done;
        logic [RD_BITS-1:0] rd_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                present;
    tgt_prof_t           prof;
    logic                phase_end;
    logic                ld, sh, smp;
    logic                tx_next;
    logic [RD_BITS-1:0]  rx_byte;
    logic [WORD_MAX-1:0] load_word;
    logic                din;
    logic [IDX_W-1:0]    last_idx;

    spi_target_map u_map (
        .idx     (req_target),
        .present (present),
        .prof    (prof)
    );

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (ld),
        .run       (ctl_q.st != ST_IDLE),
        .div       (clk_div),
        .phase_end (phase_end)
    );

    spi_shift_reg u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .load_word  (load_word),
        .shift      (sh),
        .sample     (smp),
        .sample_bit (din),
        .tx_next    (tx_next),
        .rx_byte    (rx_byte)
    );

    assign load_word = prof.long_word ? req_word
                                      : {8'h00, req_read, req_word[22:0]} << 8;
    assign din       = ctl_q.three_wire ? sdio_in : miso;
    assign last_idx  = ctl_q.long_word ? LAST_LONG : LAST_SHORT;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ld         = 1'b0;
        sh         = 1'b0;
        smp        = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!present || (req_read && !prof.readable)) begin
                        ctl_d.done    = 1'b1;
                        ctl_d.rd_data = '0;
                    end else begin
                        ld               = 1'b1;
                        ctl_d.st         = ST_LOW;
                        ctl_d.three_wire = prof.three_wire;
                        ctl_d.long_word  = prof.long_word;
                        ctl_d.is_read    = req_read;
                        ctl_d.bit_idx    = '0;
                        ctl_d.oe         = prof.three_wire;
                        ctl_d.dout       = load_word[WORD_MAX-1];
                        for (int i = 0; i < NUM_TGT; i++) begin
                            ctl_d.cs_n[i] = !(int'(req_target) == i);
                        end
                    end
                end
            end
            ST_LOW: begin
                if (phase_end) begin
                    ctl_d.sclk = 1'b1;
                    ctl_d.st   = ST_HIGH;
                    smp        = ctl_q.is_read && (ctl_q.bit_idx >= TURN_IDX);
                end
            end
            ST_HIGH: begin
                if (phase_end) begin
                    ctl_d.sclk = 1'b0;
                    if (ctl_q.bit_idx == last_idx) begin
                        ctl_d.st   = ST_HOLD;
                        ctl_d.dout = 1'b0;
                    end else begin
                        sh            = 1'b1;
                        ctl_d.st      = ST_LOW;
                        ctl_d.bit_idx = ctl_q.bit_idx + IDX_W'(1);
                        ctl_d.dout    = tx_next;
                        if (ctl_q.three_wire && ctl_q.is_read &&
                            (ctl_q.bit_idx == TURN_IDX - IDX_W'(1))) begin
                            ctl_d.oe = 1'b0;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (phase_end) begin
                    ctl_d.st      = ST_IDLE;
                    ctl_d.cs_n    = '1;
                    ctl_d.oe      = 1'b0;
                    ctl_d.done    = 1'b1;
                    ctl_d.rd_data = ctl_q.is_read ? rx_byte : '0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.cs_n <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy     = (ctl_q.st != ST_IDLE);
    assign done     = ctl_q.done;
    assign rd_data  = ctl_q.rd_data;
    assign sclk     = ctl_q.sclk;
    assign cs_n     = ctl_q.cs_n;
    assign mosi     = ctl_q.dout && !ctl_q.three_wire;
    assign sdio_out = ctl_q.dout && ctl_q.three_wire;
    assign sdio_oe  = ctl_q.oe;

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    // R4
    dout_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> ($stable(mosi) && $stable(sdio_out)));

    // R6
    fourwire_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n[0] |-> !sdio_oe);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && (&cs_n)));

    // R11
    req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(ctl_q.is_read));
endmodule

// File: tb/cfg_spi_master_test.sv
`timescale 1ns/1ps
module cfg_spi_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd2;
    logic        req_valid = 1'b0;
    logic [1:0]  req_target = 2'd0;
    logic        req_read = 1'b0;
    logic [31:0] req_word = '0;
    logic        busy, done, sclk, mosi, sdio_out, sdio_oe;
    logic [7:0]  rd_data;
    logic [2:0]  cs_n;
    logic        miso, sdio_in;

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    int          cyc = 0;
    int          edges, ndone, oe_hi, per_bad, stab_bad;
    int          t_csfall, t_csrise, t_rise1, t_prise, t_lastfall, t_done;
    int          cur_h = 1;
    logic [2:0]  cs_seen;
    logic [31:0] cap;
    logic [7:0]  got_rd;
    logic [7:0]  resp_r = '0;
    logic        hold_val;
    logic        pcsall = 1'b1;
    logic        psclk  = 1'b0;
    logic        slave_bit;

    cfg_spi_master uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_div    (clk_div),
        .req_valid  (req_valid),
        .req_target (req_target),
        .req_read   (req_read),
        .req_word   (req_word),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .miso       (miso),
        .sdio_out   (sdio_out),
        .sdio_oe    (sdio_oe),
        .sdio_in    (sdio_in)
    );

    function automatic logic resp_bit(input int e, input logic [7:0] r);
        if (e >= 16 && e < 24) return r[23 - e];
        return 1'b0;
    endfunction

    assign slave_bit = resp_bit(edges, resp_r);
    assign miso      = !cs_n[0] ? slave_bit : 1'b0;
    // shared line: loopback of the master while it drives, slave byte otherwise
    assign sdio_in   = sdio_oe ? sdio_out : ((!cs_n[1] || !cs_n[2]) ? slave_bit : 1'b0);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic csall;
        logic line;
        cyc++;
        csall = &cs_n;
        line  = !cs_n[0] ? mosi : sdio_out;
        if (done) begin
            ndone++;
            got_rd = rd_data;
            t_done = cyc;
        end
        if (!csall) cs_seen = cs_seen | ~cs_n;
        if (pcsall && !csall) t_csfall = cyc;
        if (!pcsall && csall) t_csrise = cyc;
        if (!psclk && sclk) begin
            cap = {cap[30:0], line};
            if (sdio_oe) oe_hi++;
            if (edges == 0) t_rise1 = cyc;
            else if (cyc - t_prise != 2 * cur_h) per_bad++;
            t_prise  = cyc;
            hold_val = line;
            edges++;
        end else if (psclk && sclk) begin
            if (line != hold_val) stab_bad++;
        end
        if (psclk && !sclk) t_lastfall = cyc;
        pcsall = csall;
        psclk  = sclk;
    end

    task automatic run_txn(input logic [1:0] tg, input logic rd, input logic [31:0] w,
                           input logic [7:0] resp, input logic [7:0] dv, input bit inject);
        int   nbits;
        bit   active;
        logic [31:0] exp_word, mask;
        logic [7:0]  exp_rd;
        logic [2:0]  exp_cs;
        int   exp_oe;
        logic busy_after;
        edges = 0; ndone = 0; oe_hi = 0; per_bad = 0; stab_bad = 0;
        cs_seen = '0; cap = '0; got_rd = 8'hEE;
        t_csfall = 0; t_csrise = 0; t_rise1 = 0; t_lastfall = 0; t_done = 0;
        resp_r  = resp;
        clk_div = dv;
        cur_h   = (dv == 0) ? 1 : int'(dv);
        @(negedge clk);
        req_valid = 1'b1; req_target = tg; req_read = rd; req_word = w;
        @(negedge clk);
        req_valid  = 1'b0;
        busy_after = busy;
        if (inject) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_target = 2'd0; req_read = 1'b1; req_word = 32'hFFFFFFFF;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 3000 && ndone == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        if (ndone == 0) chk(1'b0, "R10 watchdog(no done)", 0, 1);

        active   = (tg != 2'd3) && !(tg == 2'd2 && rd);
        nbits    = (tg == 2'd2) ? 32 : 24;
        exp_word = (tg == 2'd2) ? w : {8'h00, rd, w[22:0]};
        mask     = (nbits == 32) ? 32'hFFFFFFFF : 32'h00FFFFFF;
        exp_rd   = (active && rd) ? resp : 8'h00;
        exp_cs   = active ? 3'(1 << tg) : 3'b000;
        exp_oe   = (!active || tg == 2'd0) ? 0 : (rd ? 16 : nbits);

        chk(ndone == 1, "R10 done count", ndone, 1);
        chk(cs_seen == exp_cs, active ? "R1 chip select" : (tg == 2'd3 ? "R8 no select" : "R7 no select"),
            cs_seen, exp_cs);
        chk(got_rd == exp_rd, rd ? (active ? (tg == 2'd0 ? "R5 read byte" : "R6 read byte") : "R7 zero data")
                                 : "R12 write data", got_rd, exp_rd);
        if (active) begin
            chk(edges == nbits, "R3 edge count", edges, nbits);
            chk((cap & mask) == exp_word, "R3 word", cap & mask, exp_word);
            chk(oe_hi == exp_oe, "R6 oe bits", oe_hi, exp_oe);
            chk(t_rise1 - t_csfall == cur_h, "R9 setup", t_rise1 - t_csfall, cur_h);
            chk(t_csrise - t_lastfall == cur_h, "R9 hold", t_csrise - t_lastfall, cur_h);
            chk(per_bad == 0, "R9 period", per_bad, 0);
            chk(stab_bad == 0, "R4 data stable", stab_bad, 0);
            chk(t_done == t_csrise, "R10 done timing", t_done, t_csrise);
            chk(busy_after == 1'b1, "R10 busy", busy_after, 1);
        end else begin
            chk(edges == 0, tg == 2'd3 ? "R8 no clock" : "R7 no clock", edges, 0);
        end
    endtask

    localparam int NV = 7;
    // {target[50:49], read[48], word[47:16], resp[15:8], div[7:0]}
    localparam logic [50:0] VEC [NV] = '{
        {2'd0, 1'b0, 32'h00923456, 8'h00, 8'd2},
        {2'd0, 1'b1, 32'h001A2B00, 8'hA5, 8'd1},
        {2'd1, 1'b0, 32'h0055AA33, 8'h00, 8'd3},
        {2'd1, 1'b1, 32'h00003100, 8'hC3, 8'd2},
        {2'd2, 1'b0, 32'hDEADBEEF, 8'h00, 8'd1},
        {2'd2, 1'b1, 32'h12345678, 8'hFF, 8'd1},
        {2'd3, 1'b0, 32'h00ABCDEF, 8'h00, 8'd2}
    };

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(cs_n == 3'b111, "R2 reset cs", cs_n, 3'b111);
        chk(sclk == 1'b0, "R4 reset sclk", sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R10 reset flags", {busy, done}, 0);
        chk(sdio_oe == 1'b0, "R6 reset oe", sdio_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_txn(VEC[v][50:49], VEC[v][48], VEC[v][47:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
        end

        // R9 divider of zero behaves as one
        run_txn(2'd1, 1'b1, 32'h00007700, 8'h3C, 8'd0, 1'b0);
        // R11 request while busy is ignored
        run_txn(2'd1, 1'b0, 32'h00F0F0F0, 8'h00, 8'd2, 1'b1);
        // R11 then a normal converter read still works
        run_txn(2'd0, 1'b1, 32'h00000000, 8'h81, 8'd3, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R10 global watchdog: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule